// File: doc/BRIEF.md
# Opcode Usage Frequency Counter

This block sits beside an ALU's function-select input and measures how often one chosen function is used. A dedicated trigger code on the select arms the block. While the trigger is present, the low bits of operand A name the function code to watch. From the next cycle onward, every cycle that carries the watched code adds one to an internal tally.

When the trigger code appears again, the block drives the tally onto its result port in that same cycle, so the ALU's output multiplexer can forward it as the operation's result. At the following clock edge the block clears the tally and re-arms on whatever code operand A now carries. Reports can therefore be chained, and each one moves the watch to a different function. The tally saturates instead of wrapping.

Top module: `opcode_usage_counter`

## Requirements
- R1: After reset, the first cycle with the trigger code on `func_sel` shows a `result` of zero.
- R2: The trigger code is 3'b111. In a cycle with the trigger, `result` equals the current tally, with no register delay. In every other cycle, `result` is zero.
- R3: At each trigger, the watched code is taken from `opnd_a[2:0]`. Bits `opnd_a[15:3]` have no effect on which code is watched.
- R4: While armed, each clock cycle in which `func_sel` equals the watched code, and is not the trigger, adds exactly one to the tally.
- R5: Cycles that carry any other non-trigger code leave the tally unchanged.
- R6: Between reset and the first trigger, no cycle counts, whatever appears on `func_sel`.
- R7: Every trigger reports the tally, then clears it and re-arms on the newly supplied code. Successive triggers may name different codes.
- R8: If the watched code is the trigger code itself, nothing is ever counted, and the next report is zero.
- R9: The tally stops at 16'hFFFF and never wraps. A tally of 16'hFFFE is still reported as 16'hFFFE.
- R10: Synchronous reset (`rst` high at a clock edge) clears the tally and disarms the block. After reset, cycles carrying the previously watched code do not count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| func_sel | input | 3 | ALU function select for this cycle |
| opnd_a | input | 16 | Operand A; its low 3 bits name the code to watch when the trigger is present |
| result | output | 16 | Tally while the trigger is present, otherwise zero |

## Verification
The bench goes after four kinds of fault.

- **Counting before the first arm.** A block that counted before its first arm would report a non-zero value at the first trigger.
- **Wrong capture of the watched code.** A block that took its watch code from the wrong operand bits would count the wrong function after an arm that sets the upper bits of A. A block that let the trigger code count itself would report a non-zero value after watching 3'b111.
- **Faults around a report.** A block that failed to clear the tally would carry counts across a report. A block that kept its armed state through reset would count after reset.
- **Faults at the top of the range.** The bench runs long enough to reach the limit. A wrapping tally would report a small number where 16'hFFFF is expected. An early clamp would corrupt the 16'hFFFE case.

// File: rtl/opcnt_pkg.sv
package opcnt_pkg;
   localparam int unsigned DEF_DATA_W = 16;
   localparam int unsigned DEF_SEL_W  = 3;
endpackage

// File: rtl/opcnt_target.sv
module opcnt_target #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] src,
   output logic              armed,
   output logic [SEL_W-1:0]  code
);
   always_ff @(posedge clk) begin
      if (rst) begin
         armed <= 1'b0;
         code  <= '0;
      end else if (load) begin
         armed <= 1'b1;
         code  <= src[SEL_W-1:0];
      end
   end
endmodule

// File: rtl/opcnt_accum.sv
module opcnt_accum #(
   parameter int unsigned DATA_W   = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              inc,
   output logic [DATA_W-1:0] cnt
);
   localparam logic [DATA_W-1:0] TOP = '1;
   logic [DATA_W-1:0] nxt;

   generate
      if (SATURATE) begin : g_sat
         always_comb nxt = (cnt == TOP) ? TOP : cnt + 1'b1;
      end else begin : g_wrap
         always_comb nxt = cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr) cnt <= '0;
      else if (inc)   cnt <= nxt;
   end
endmodule

// File: rtl/opcode_usage_counter.sv
module opcode_usage_counter
   import opcnt_pkg::*;
#(
   parameter int unsigned DATA_W    = DEF_DATA_W,
   parameter int unsigned SEL_W     = DEF_SEL_W,
   parameter logic [SEL_W-1:0] TRIG_CODE = '1,
   parameter bit          SATURATE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [SEL_W-1:0]  func_sel,
   input  logic [DATA_W-1:0] opnd_a,
   output logic [DATA_W-1:0] result
);
   generate
      if (SEL_W < 1 || SEL_W > DATA_W) begin : g_bad_sel
         $error("SEL_W must lie in 1..DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
   endgenerate

   logic              trig;
   logic              hit;
   logic              armed_q;
   logic [SEL_W-1:0]  code_q;
   logic [DATA_W-1:0] cnt_q;

   assign trig = (func_sel == TRIG_CODE);
   assign hit  = armed_q && !trig && (func_sel == code_q);

   opcnt_target #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_target (
      .clk   (clk),
      .rst   (rst),
      .load  (trig),
      .src   (opnd_a),
      .armed (armed_q),
      .code  (code_q)
   );

   opcnt_accum #(.DATA_W(DATA_W), .SATURATE(SATURATE)) u_accum (
      .clk (clk),
      .rst (rst),
      .clr (trig),
      .inc (hit),
      .cnt (cnt_q)
   );

   assign result = trig ? cnt_q : '0;
endmodule

// File: rtl/opcnt_checker.sv
module opcnt_checker #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned SEL_W     = 3,
   parameter logic [SEL_W-1:0] TRIG_CODE = '1,
   parameter bit          SATURATE  = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic [SEL_W-1:0]  func_sel,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] result,
   input logic [DATA_W-1:0] cnt,
   input logic              armed,
   input logic [SEL_W-1:0]  code
);
   localparam logic [DATA_W-1:0] TOP = '1;

   a_r10_reset_clears: assert property (@(posedge clk)
      rst |=> (!armed && cnt == '0));

   a_r7_report_clears: assert property (@(posedge clk) disable iff (rst)
      (func_sel == TRIG_CODE) |=> (cnt == '0));

   a_r3_capture: assert property (@(posedge clk) disable iff (rst)
      (func_sel == TRIG_CODE) |=> (armed && code == $past(opnd_a[SEL_W-1:0])));

   a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
      !armed |-> (cnt == '0));

   a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      (func_sel != TRIG_CODE && (!armed || func_sel != code)) |=> $stable(cnt));

   a_r4_step: assert property (@(posedge clk) disable iff (rst)
      (func_sel != TRIG_CODE && armed && func_sel == code && cnt != TOP)
      |=> (cnt == $past(cnt) + 1'b1));

   generate
      if (SATURATE) begin : g_sat_chk
         a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
            (func_sel != TRIG_CODE && armed && func_sel == code && cnt == TOP)
            |=> (cnt == TOP));
      end
   endgenerate

   a_r2_report_src: assert property (@(posedge clk) disable iff (rst)
      (func_sel == TRIG_CODE && $past(func_sel) != TRIG_CODE && !$past(rst))
      |-> (result == cnt));
endmodule

bind opcode_usage_counter opcnt_checker #(
   .DATA_W(DATA_W), .SEL_W(SEL_W), .TRIG_CODE(TRIG_CODE), .SATURATE(SATURATE)
) u_chk (
   .clk(clk), .rst(rst), .func_sel(func_sel), .opnd_a(opnd_a),
   .result(result), .cnt(cnt_q), .armed(armed_q), .code(code_q)
);

// File: tb/opcode_usage_counter_bench.sv
`timescale 1ns/1ps
module opcode_usage_counter_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  func_sel = 3'd0;
   logic [15:0] opnd_a = 16'h0;
   logic [15:0] result;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   opcode_usage_counter u_opcode_usage_counter (
      .clk(clk), .rst(rst), .func_sel(func_sel), .opnd_a(opnd_a), .result(result)
   );

   // {sel, operand A, expected result}
   localparam int NV = 22;
   localparam logic [34:0] VEC [NV] = '{
      {3'd2, 16'h0000, 16'h0000},  // R6 not armed
      {3'd2, 16'h0000, 16'h0000},  // R6
      {3'd7, 16'h0002, 16'h0000},  // R1 first report zero, arm 2
      {3'd2, 16'h0000, 16'h0000},  // R4 count 1
      {3'd3, 16'h0000, 16'h0000},  // R5
      {3'd2, 16'h0000, 16'h0000},  // count 2
      {3'd0, 16'h0000, 16'h0000},  // R5
      {3'd2, 16'h0000, 16'h0000},  // count 3
      {3'd7, 16'hFFF5, 16'h0003},  // R2 R3 report 3, arm 5
      {3'd5, 16'h0000, 16'h0000},
      {3'd5, 16'h0000, 16'h0000},
      {3'd4, 16'h0000, 16'h0000},
      {3'd7, 16'h0007, 16'h0002},  // R7 report 2, arm 7
      {3'd1, 16'h0000, 16'h0000},
      {3'd6, 16'h0000, 16'h0000},
      {3'd7, 16'h0001, 16'h0000},  // R8 watching trigger: zero, arm 1
      {3'd1, 16'h0000, 16'h0000},
      {3'd1, 16'h0000, 16'h0000},
      {3'd1, 16'h0000, 16'h0000},
      {3'd7, 16'h0000, 16'h0003},  // R4 R7 report 3, arm 0
      {3'd0, 16'h0000, 16'h0000},
      {3'd7, 16'h0000, 16'h0001}   // R7 report 1
   };

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: result=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic step(input logic [2:0] s, input logic [15:0] a);
      @(negedge clk);
      func_sel = s;
      opnd_a   = a;
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      func_sel = 3'd0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 190000) begin
         n_bad++;
         $display("FAIL watchdog: cycles=%0d expected=<190000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: immediate trigger after reset
      step(3'd7, 16'h0003);
      check("R1", result, 16'h0000);
      // R2: non-trigger cycles read zero
      step(3'd3, 16'h0000);
      check("R2", result, 16'h0000);

      do_reset();
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][34:32], VEC[i][31:16]);
         check("R2 vector", result, VEC[i][15:0]);
      end

      // R10: reset disarms mid-run
      step(3'd7, 16'h0003);
      repeat (4) step(3'd3, 16'h0000);
      do_reset();
      repeat (3) step(3'd3, 16'h0000);
      step(3'd7, 16'h0006);
      check("R10", result, 16'h0000);

      // R9: one below the limit, armed on code 6 by the previous trigger
      for (int i = 0; i < 65534; i++) step(3'd6, 16'h0000);
      step(3'd7, 16'h0006);
      check("R9 below limit", result, 16'hFFFE);
      // R9: past the limit
      for (int i = 0; i < 65537; i++) step(3'd6, 16'h0000);
      step(3'd7, 16'h0004);
      check("R9 saturate", result, 16'hFFFF);
      step(3'd7, 16'h0004);
      check("R7 cleared after saturate", result, 16'h0000);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule